// File: doc/BRIEF.md
# Occupancy-Aware Virtual Channel Allocator

This block assigns output virtual channels to packets waiting at the input virtual channels of a five-port mesh router. Each port carries two VCs and each VC buffers four flits. A VC may hold several whole packets at once, so a new head flit can be placed in a VC that still holds earlier traffic. Allocation is separable. In the first stage, each requesting input VC picks one output VC. It looks at the primary port first. If no VC there has room, it falls back to the alternate port. Among the VCs that fit, it prefers the one with the fewest packets resident. In the second stage, a round-robin arbiter per output VC picks one winner among the bids it received.

Each packet carries a count of how often it has met a full output. Route computation uses this count to decide when to fall back to deterministic routing. The allocator returns the updated count every cycle: one more for each port it found full, saturating at the top of the counter. The allocator keeps its own count of packets resident in each output VC. The count rises on a grant and falls when the switch reports that a tail flit has left.

Top module: `vca_occupancy_alloc`

## Requirements
- R1: A requesting input VC whose primary port has at least one fitting VC bids on the fitting VC of that port with the fewest resident packets. On equal counts, the lower VC index (port*2+vc) wins. The returned full-buffer count equals the incoming one.
- R2: If no VC of the primary port fits but one of the alternate port does, the bid goes to the least-loaded fitting VC of the alternate port, with the same tie rule. The returned count is the incoming count plus one.
- R3: If neither port has a fitting VC, the input VC gets no grant that cycle, and the returned count is the incoming count plus two.
- R4: The returned full-buffer count saturates at 2^FOB_W-1 (31 by default) and never wraps.
- R5: A VC fits a packet when its free-slot count is at least min(length, VC_DEPTH). A packet longer than the buffer therefore needs an empty VC. A VC that already holds packets can still be granted.
- R6: Each output VC is granted to at most one input VC per cycle. Contending bidders are served in round-robin order: the search starts just past the previous winner's index, and a granted bidder moves to the back.
- R7: An input VC that is not requesting, or that loses arbitration, sees grant low and gnt_ovc zero. It still receives its full-buffer count: for a loser, the value computed for its bid; for a non-requester, its incoming value unchanged.
- R8: The packet count of an output VC rises by one on the clock edge after a grant to it and falls by one on the edge after its tail-leave input is high. The count is unchanged when both happen together. It is reported on ovc_pkts.
- R9: After synchronous reset, all packet counts are zero. The round-robin search of every output VC starts at input index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | NVC | Input VC i holds a routed head flit |
| in_port_pri | input | NVC*PW | Primary output port for each input VC |
| in_port_alt | input | NVC*PW | Alternate output port for each input VC |
| in_len | input | NVC*LEN_W | Packet length in flits (1..5) |
| in_fob | input | NVC*FOB_W | Incoming full-buffer count of each packet |
| out_free_slots | input | NVC*SLOT_W | Free flit slots of each output VC |
| out_tail_leave | input | NVC | A tail flit leaves output VC o this cycle |
| gnt | output | NVC | Input VC i granted this cycle |
| gnt_ovc | output | NVC*OW | Granted output VC index (port*NUM_VCS+vc), zero if not granted |
| fob_upd | output | NVC*FOB_W | Updated full-buffer count for each input VC |
| ovc_pkts | output | NVC*CNT_W | Packets resident in each output VC |

## Verification
A long pseudo-random sweep changes the requester, both ports, the length, the incoming count and every free-slot value each cycle. Free slots are kept consistent with the resident packet counts. This reaches every fallback depth, the ties between equal-load VCs, the saturation at 31, and five-flit packets that need an empty VC. A design that skips the alternate port, counts a miss when the primary port fits, wraps the counter, or checks the raw length against free slots would grant the wrong VC or return a wrong count. Directed contention shows the order 2, 7, 2 on one output VC; a fixed-priority arbiter would return 2 three times. Other directed steps show a second packet granted into a VC that already holds one. The packet counts are compared every cycle against a model, so a dropped increment or decrement is caught.

// File: rtl/vca_pkg.sv
package vca_pkg;

    localparam int VCA_PORTS = 5;
    localparam int VCA_VCS   = 2;
    localparam int VCA_DEPTH = 4;
    localparam int VCA_FOB_W = 5;
    localparam int VCA_LEN_W = 3;

    // Where a stage-one bid ended up.
    typedef enum logic [1:0] {
        SRC_NONE      = 2'd0,
        SRC_PRIMARY   = 2'd1,
        SRC_ALTERNATE = 2'd2
    } bid_src_e;

    // Slots that must be free to take a whole packet; longer packets need an empty VC.
    function automatic int slots_needed(int len, int depth);
        return (len > depth) ? depth : len;
    endfunction

    // Number of full ports met on the way to the bid.
    function automatic int misses_of(bid_src_e src, logic req);
        if (!req) return 0;
        case (src)
            SRC_PRIMARY:   return 0;
            SRC_ALTERNATE: return 1;
            default:       return 2;
        endcase
    endfunction

endpackage

// File: rtl/vca_rr_arbiter.sv
module vca_rr_arbiter #(
    parameter  int N  = 10,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic [IW-1:0] ptr;
    logic          found;
    int            win;
    int            idx;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        win   = 0;
        idx   = 0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = idx;
            end
        end
        if (found) gnt[win] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= (win + 1 >= N) ? '0 : IW'(win + 1);
        end
    end

endmodule

// File: rtl/vca_pkt_counter.sv
module vca_pkt_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0) cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/vca_bid_select.sv
module vca_bid_select
    import vca_pkg::*;
#(
    parameter  int NUM_PORTS = VCA_PORTS,
    parameter  int NUM_VCS   = VCA_VCS,
    parameter  int VC_DEPTH  = VCA_DEPTH,
    parameter  int FOB_W     = VCA_FOB_W,
    parameter  int LEN_W     = VCA_LEN_W,
    localparam int NOUT      = NUM_PORTS * NUM_VCS,
    localparam int PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int OW        = (NOUT > 1) ? $clog2(NOUT) : 1,
    localparam int SLOT_W    = $clog2(VC_DEPTH + 1),
    localparam int CNT_W     = SLOT_W
) (
    input  logic                        req_valid,
    input  logic [PW-1:0]               port_pri,
    input  logic [PW-1:0]               port_alt,
    input  logic [LEN_W-1:0]            pkt_len,
    input  logic [FOB_W-1:0]            fob_in,
    input  logic [NOUT-1:0][SLOT_W-1:0] free_slots,
    input  logic [NOUT-1:0][CNT_W-1:0]  pkt_cnt,
    output logic                        bid_valid,
    output logic [OW-1:0]               bid_ovc,
    output logic [FOB_W-1:0]            fob_out
);

    localparam int FOB_MAX = (1 << FOB_W) - 1;

    int             need;
    logic [NUM_PORTS-1:0] port_fit;
    int             port_pick [NUM_PORTS];
    int             best_cnt  [NUM_PORTS];

    // Per port: does any VC take the whole packet, and which one is least loaded.
    always_comb begin
        need = slots_needed(int'(pkt_len), VC_DEPTH);
        for (int p = 0; p < NUM_PORTS; p++) begin
            port_fit[p]  = 1'b0;
            port_pick[p] = 0;
            best_cnt[p]  = 0;
            for (int v = 0; v < NUM_VCS; v++) begin
                if (int'(free_slots[p*NUM_VCS+v]) >= need &&
                    (!port_fit[p] || int'(pkt_cnt[p*NUM_VCS+v]) < best_cnt[p])) begin
                    port_fit[p]  = 1'b1;
                    port_pick[p] = v;
                    best_cnt[p]  = int'(pkt_cnt[p*NUM_VCS+v]);
                end
            end
        end
    end

    bid_src_e src;
    int       hit_port;
    int       fob_sum;

    always_comb begin
        src      = SRC_NONE;
        hit_port = 0;
        if (req_valid) begin
            if (int'(port_pri) < NUM_PORTS && port_fit[port_pri]) begin
                src      = SRC_PRIMARY;
                hit_port = int'(port_pri);
            end else if (int'(port_alt) < NUM_PORTS && port_fit[port_alt]) begin
                src      = SRC_ALTERNATE;
                hit_port = int'(port_alt);
            end
        end
        bid_valid = req_valid && (src != SRC_NONE);
        bid_ovc   = bid_valid ? OW'(hit_port * NUM_VCS + port_pick[hit_port]) : '0;
        fob_sum   = int'(fob_in) + misses_of(src, req_valid);
        fob_out   = (fob_sum > FOB_MAX) ? FOB_W'(FOB_MAX) : FOB_W'(fob_sum);
    end

endmodule

// File: rtl/vca_occupancy_alloc.sv
module vca_occupancy_alloc
    import vca_pkg::*;
#(
    parameter  int NUM_PORTS = VCA_PORTS,
    parameter  int NUM_VCS   = VCA_VCS,
    parameter  int VC_DEPTH  = VCA_DEPTH,
    parameter  int FOB_W     = VCA_FOB_W,
    parameter  int LEN_W     = VCA_LEN_W,
    localparam int NVC       = NUM_PORTS * NUM_VCS,
    localparam int PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int OW        = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int SLOT_W    = $clog2(VC_DEPTH + 1),
    localparam int CNT_W     = SLOT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NVC-1:0]        in_req,
    input  logic [NVC*PW-1:0]     in_port_pri,
    input  logic [NVC*PW-1:0]     in_port_alt,
    input  logic [NVC*LEN_W-1:0]  in_len,
    input  logic [NVC*FOB_W-1:0]  in_fob,
    input  logic [NVC*SLOT_W-1:0] out_free_slots,
    input  logic [NVC-1:0]        out_tail_leave,
    output logic [NVC-1:0]        gnt,
    output logic [NVC*OW-1:0]     gnt_ovc,
    output logic [NVC*FOB_W-1:0]  fob_upd,
    output logic [NVC*CNT_W-1:0]  ovc_pkts
);

    logic [NVC-1:0][SLOT_W-1:0] free_arr;
    logic [NVC-1:0][CNT_W-1:0]  cnt_arr;
    logic [NVC-1:0]             bid_v;
    logic [NVC-1:0][OW-1:0]     bid_o;
    logic [NVC-1:0][NVC-1:0]    bid_to;   // [output VC][input VC]
    logic [NVC-1:0][NVC-1:0]    won;      // [output VC][input VC]

    assign free_arr = out_free_slots;
    assign ovc_pkts = cnt_arr;

    // Stage one: one bid per input VC.
    for (genvar i = 0; i < NVC; i++) begin : g_stage1
        vca_bid_select #(
            .NUM_PORTS (NUM_PORTS),
            .NUM_VCS   (NUM_VCS),
            .VC_DEPTH  (VC_DEPTH),
            .FOB_W     (FOB_W),
            .LEN_W     (LEN_W)
        ) u_sel (
            .req_valid  (in_req[i]),
            .port_pri   (in_port_pri[i*PW +: PW]),
            .port_alt   (in_port_alt[i*PW +: PW]),
            .pkt_len    (in_len[i*LEN_W +: LEN_W]),
            .fob_in     (in_fob[i*FOB_W +: FOB_W]),
            .free_slots (free_arr),
            .pkt_cnt    (cnt_arr),
            .bid_valid  (bid_v[i]),
            .bid_ovc    (bid_o[i]),
            .fob_out    (fob_upd[i*FOB_W +: FOB_W])
        );
    end

    always_comb begin
        for (int o = 0; o < NVC; o++) begin
            for (int i = 0; i < NVC; i++) begin
                bid_to[o][i] = bid_v[i] && (int'(bid_o[i]) == o);
            end
        end
    end

    // Stage two: one arbiter and one occupancy counter per output VC.
    for (genvar o = 0; o < NVC; o++) begin : g_stage2
        vca_rr_arbiter #(
            .N (NVC)
        ) u_arb (
            .clk (clk),
            .rst (rst),
            .req (bid_to[o]),
            .gnt (won[o])
        );

        vca_pkt_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (|won[o]),
            .dec (out_tail_leave[o]),
            .cnt (cnt_arr[o])
        );
    end

    always_comb begin
        gnt     = '0;
        gnt_ovc = '0;
        for (int i = 0; i < NVC; i++) begin
            for (int o = 0; o < NVC; o++) begin
                if (won[o][i]) gnt[i] = 1'b1;
            end
            gnt_ovc[i*OW +: OW] = gnt[i] ? bid_o[i] : '0;
        end
    end

endmodule

// File: rtl/vca_alloc_checker.sv
module vca_alloc_checker #(
    parameter  int NUM_PORTS = 5,
    parameter  int NUM_VCS   = 2,
    parameter  int VC_DEPTH  = 4,
    parameter  int FOB_W     = 5,
    parameter  int LEN_W     = 3,
    localparam int NVC       = NUM_PORTS * NUM_VCS,
    localparam int OW        = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int SLOT_W    = $clog2(VC_DEPTH + 1),
    localparam int CNT_W     = SLOT_W
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NVC-1:0]        in_req,
    input logic [NVC*LEN_W-1:0]  in_len,
    input logic [NVC*FOB_W-1:0]  in_fob,
    input logic [NVC*SLOT_W-1:0] out_free_slots,
    input logic [NVC-1:0]        out_tail_leave,
    input logic [NVC-1:0]        gnt,
    input logic [NVC*OW-1:0]     gnt_ovc,
    input logic [NVC*FOB_W-1:0]  fob_upd,
    input logic [NVC*CNT_W-1:0]  ovc_pkts
);

    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [NVC-1:0][NVC-1:0] owner;   // [output VC][input VC]
    logic [NVC-1:0]          fits;

    always_comb begin
        for (int o = 0; o < NVC; o++) begin
            for (int i = 0; i < NVC; i++) begin
                owner[o][i] = gnt[i] && (int'(gnt_ovc[i*OW +: OW]) == o);
            end
        end
        for (int i = 0; i < NVC; i++) begin
            fits[i] = 1'b0;
            for (int o = 0; o < NVC; o++) begin
                if (int'(gnt_ovc[i*OW +: OW]) == o &&
                    int'(out_free_slots[o*SLOT_W +: SLOT_W]) >=
                    ((int'(in_len[i*LEN_W +: LEN_W]) > VC_DEPTH) ? VC_DEPTH
                                                                 : int'(in_len[i*LEN_W +: LEN_W])))
                    fits[i] = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NVC; i++) begin : g_in
        p_grant_has_request_r7: assert property (@(posedge clk) disable iff (rst)
            gnt[i] |-> in_req[i]);

        p_whole_packet_fits_r5: assert property (@(posedge clk) disable iff (rst)
            gnt[i] |-> fits[i]);

        p_fob_step_r2: assert property (@(posedge clk) disable iff (rst)
            in_req[i] |-> (int'(fob_upd[i*FOB_W +: FOB_W]) >= int'(in_fob[i*FOB_W +: FOB_W]) &&
                           int'(fob_upd[i*FOB_W +: FOB_W]) <= int'(in_fob[i*FOB_W +: FOB_W]) + 2));

        p_fob_passthru_r7: assert property (@(posedge clk) disable iff (rst)
            !in_req[i] |-> (fob_upd[i*FOB_W +: FOB_W] == in_fob[i*FOB_W +: FOB_W]));
    end

    for (genvar o = 0; o < NVC; o++) begin : g_out
        p_single_owner_r6: assert property (@(posedge clk) disable iff (rst)
            $onehot0(owner[o]));

        p_count_up_r8: assert property (@(posedge clk) disable iff (rst)
            ((|owner[o]) && !out_tail_leave[o] && int'(ovc_pkts[o*CNT_W +: CNT_W]) != CNT_MAX)
            |=> (int'(ovc_pkts[o*CNT_W +: CNT_W]) == int'($past(ovc_pkts[o*CNT_W +: CNT_W])) + 1));

        p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
            (!(|owner[o]) && out_tail_leave[o] && int'(ovc_pkts[o*CNT_W +: CNT_W]) != 0)
            |=> (int'(ovc_pkts[o*CNT_W +: CNT_W]) == int'($past(ovc_pkts[o*CNT_W +: CNT_W])) - 1));
    end

endmodule

bind vca_occupancy_alloc vca_alloc_checker #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_VCS   (NUM_VCS),
    .VC_DEPTH  (VC_DEPTH),
    .FOB_W     (FOB_W),
    .LEN_W     (LEN_W)
) u_vca_chk (
    .clk            (clk),
    .rst            (rst),
    .in_req         (in_req),
    .in_len         (in_len),
    .in_fob         (in_fob),
    .out_free_slots (out_free_slots),
    .out_tail_leave (out_tail_leave),
    .gnt            (gnt),
    .gnt_ovc        (gnt_ovc),
    .fob_upd        (fob_upd),
    .ovc_pkts       (ovc_pkts)
);

// File: tb/vca_occupancy_alloc_bench.sv
module vca_occupancy_alloc_bench;

    localparam int NVC = 10, PW = 3, OW = 4, SW = 3, CW = 3, FW = 5, LW = 3;
    localparam int DEPTH = 4, NVCS = 2, FOB_MAX = 31;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz
    logic rst;

    logic [NVC-1:0]    req, tail;
    int                b_pri [NVC], b_alt [NVC], b_len [NVC], b_fob [NVC], b_free [NVC];
    logic [NVC*PW-1:0] f_pri, f_alt;
    logic [NVC*LW-1:0] f_len;
    logic [NVC*FW-1:0] f_fob;
    logic [NVC*SW-1:0] f_free;
    logic [NVC-1:0]    gnt;
    logic [NVC*OW-1:0] gnt_ovc;
    logic [NVC*FW-1:0] fob_upd;
    logic [NVC*CW-1:0] ovc_pkts;

    always_comb begin
        for (int i = 0; i < NVC; i++) begin
            f_pri[i*PW +: PW]  = PW'(b_pri[i]);
            f_alt[i*PW +: PW]  = PW'(b_alt[i]);
            f_len[i*LW +: LW]  = LW'(b_len[i]);
            f_fob[i*FW +: FW]  = FW'(b_fob[i]);
            f_free[i*SW +: SW] = SW'(b_free[i]);
        end
    end

    vca_occupancy_alloc u_vca_occupancy_alloc (
        .clk (clk), .rst (rst), .in_req (req), .in_port_pri (f_pri), .in_port_alt (f_alt),
        .in_len (f_len), .in_fob (f_fob), .out_free_slots (f_free), .out_tail_leave (tail),
        .gnt (gnt), .gnt_ovc (gnt_ovc), .fob_upd (fob_upd), .ovc_pkts (ovc_pkts)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    int mcnt [NVC];
    int unsigned seed = 32'h2545_f491;

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    // Least-loaded fitting VC of port p, or -1.
    function automatic int best_in(int p, int need);
        int b = -1;
        for (int v = 0; v < NVCS; v++) begin
            int o = p * NVCS + v;
            if (b_free[o] >= need && (b < 0 || mcnt[o] < mcnt[b])) b = o;
        end
        return b;
    endfunction

    task automatic idle_inputs();
        for (int i = 0; i < NVC; i++) begin
            b_pri[i] = 0; b_alt[i] = 0; b_len[i] = 1; b_fob[i] = 0; b_free[i] = 0;
        end
        req  = '0;
        tail = '0;
    endtask

    // Entered at a falling edge; compares, lets the rising edge pass, updates the model.
    // winner >= 0: all requesters bid the same VC and only that one should win.
    task automatic eval_and_step(input int winner);
        int exp_o [NVC];
        #2;
        for (int o = 0; o < NVC; o++)
            check($sformatf("R8 count ovc%0d", o), int'(ovc_pkts[o*CW +: CW]), mcnt[o]);
        for (int i = 0; i < NVC; i++) begin
            exp_o[i] = -1;
            if (req[i]) begin
                int need = (b_len[i] > DEPTH) ? DEPTH : b_len[i];
                int m = 0;
                int b = best_in(b_pri[i], need);
                int ef;
                bit ev;
                string tg;
                if (b < 0) begin m = 1; b = best_in(b_alt[i], need); end
                if (b < 0) m = 2;
                ef = (b_fob[i] + m > FOB_MAX) ? FOB_MAX : b_fob[i] + m;
                ev = (b >= 0) && (winner < 0 || winner == i);
                tg = (m == 0) ? "R1" : (m == 1) ? "R2" : "R3";
                if (b_fob[i] + m > FOB_MAX) tg = {tg, "/R4"};
                if (b >= 0 && (b_len[i] > DEPTH || mcnt[b] > 0)) tg = {tg, "/R5"};
                if (winner >= 0) tg = {tg, "/R6"};
                if (!ev) tg = {tg, "/R7"};
                check($sformatf("%s grant in%0d", tg, i), int'(gnt[i]), int'(ev));
                check($sformatf("%s ovc in%0d", tg, i), int'(gnt_ovc[i*OW +: OW]), ev ? b : 0);
                check($sformatf("%s fob in%0d", tg, i), int'(fob_upd[i*FW +: FW]), ef);
                if (ev) exp_o[i] = b;
            end else begin
                check($sformatf("R7 idle grant in%0d", i), int'(gnt[i]), 0);
                check($sformatf("R7 idle fob in%0d", i), int'(fob_upd[i*FW +: FW]), b_fob[i]);
            end
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NVC; i++)
            if (exp_o[i] >= 0 && mcnt[exp_o[i]] < 7) mcnt[exp_o[i]]++;
        for (int o = 0; o < NVC; o++)
            if (tail[o] && mcnt[o] > 0) mcnt[o]--;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int o = 0; o < NVC; o++) mcnt[o] = 0;
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: counts start at zero, nothing granted.
        #1;
        for (int o = 0; o < NVC; o++)
            check($sformatf("R9 reset count ovc%0d", o), int'(ovc_pkts[o*CW +: CW]), 0);
        check("R9 reset grants", int'(gnt), 0);
        @(negedge clk);

        // R6/R9: inputs 2 and 7 fight for VC 2; order from reset is 2, 7, 2.
        idle_inputs();
        req[2] = 1'b1; req[7] = 1'b1;
        b_pri[2] = 1; b_alt[2] = 1; b_fob[2] = 3;
        b_pri[7] = 1; b_alt[7] = 1; b_fob[7] = 9;
        b_free[2] = 1; b_free[3] = 0;
        eval_and_step(2);
        eval_and_step(7);
        eval_and_step(2);

        // R5: a 5-flit packet needs an empty VC, so VC 7 is chosen over VC 6.
        idle_inputs();
        req[0] = 1'b1; b_pri[0] = 3; b_alt[0] = 3; b_len[0] = 5;
        b_free[6] = 3; b_free[7] = 4;
        eval_and_step(-1);
        // R5: VC 7 already holds a packet and still takes another one.
        b_len[0] = 2; b_free[6] = 0; b_free[7] = 3;
        eval_and_step(-1);

        // Sweep with one requester per cycle.
        for (int c = 0; c < 3000; c++) begin
            int r = c % NVC;
            idle_inputs();
            for (int i = 0; i < NVC; i++) b_fob[i] = int'(rnd() % 32);
            req[r]   = 1'b1;
            b_pri[r] = int'(rnd() % 5);
            b_alt[r] = int'(rnd() % 5);
            b_len[r] = 1 + int'(rnd() % 5);
            if (c % 7 == 0) b_fob[r] = 30 + int'(rnd() % 2);
            for (int o = 0; o < NVC; o++) begin
                b_free[o] = int'(rnd() % unsigned'(DEPTH - mcnt[o] + 1));
                tail[o]   = (mcnt[o] > 0) && rnd()[3];
            end
            eval_and_step(-1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule